// File: doc/BRIEF.md
# DMA Channel Address and Count Bank

This block holds the working registers of a four-channel DMA engine. Each channel has a 16-bit memory address and a 16-bit count register. The low 14 bits of the count register give the remaining transfer cycles minus one. The top two bits give the transfer type. Software loads these registers one byte at a time through a small register port. A control byte turns channels on and off and selects two options: stopping a channel at terminal count, and reloading channel 2.

The surrounding engine reports each finished transfer cycle on a per-channel strobe. On each strobe for an enabled channel, the bank adds one to the address and subtracts one from the count. Two outputs are derived from the remaining count:
- a terminal-count flag for the final cycle;
- a mark flag every 128 cycles, counted back from the end of the block.

Each channel has a status bit that records a completed block. The bit stays set until software reads the status byte. When reload is selected, channel 2 takes channel 3's address and count at the end of its block, so a chained second block starts at once.

Top module: `dmacb_bank`

## Requirements
- R1: After reset, every address and count register is zero, the byte pointer selects the low byte, all channels are disabled, all status bits are clear, and `tc_o` and `mark_o` are zero.
- R2: Register address 2n selects channel n's address register and 2n+1 its count register (n = 0..3). Each access, read or write, toggles a shared byte pointer. The first access touches bits 7:0 and the second touches bits 15:8.
- R3: A write to register address 8 (the control byte) returns the byte pointer to the low byte.
- R4: The control byte is laid out as follows: bits 3:0 are the channel enables (also driven on `ch_en`), bit 6 selects stop-at-terminal-count, and bit 7 selects channel 2 reload.
- R5: A `xfer_done[n]` pulse on an enabled channel increments its address by one and decrements count bits 13:0 by one. Count bits 15:14 are left unchanged. A pulse on a disabled channel changes nothing.
- R6: `tc_o[n]` is high while channel n is enabled and its count bits 13:0 are zero. A count loaded with N-1 therefore flags the Nth transfer.
- R7: `mark_o[n]` is high while channel n is enabled and its count bits 6:0 are zero, that is, at every 128-cycle multiple counted back from the last transfer.
- R8: Reading register address 8 returns the status bits in bits 3:0, with all other bits zero. Status bit n is set by a transfer on channel n while `tc_o[n]` is high. It stays set until a status read, and it is cleared on the clock edge that ends that read.
- R9: With stop-at-terminal-count selected, the final transfer of a channel clears that channel's enable bit. Later pulses on that channel are then ignored.
- R10: With reload selected, channel 2's final transfer loads channel 3's address and full count into channel 2 instead of stepping it. Channel 2 stays enabled, and channel 3 is unchanged.
- R11: Without stop or reload, the final transfer wraps count bits 13:0 to 3FFF (hex). The channel stays enabled.
- R12: `ch_type` bits 2n+1:2n mirror count bits 15:14 of channel n, with 00 verify, 01 write, 10 read and 11 illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `reg_addr` |
| xfer_done | input | 4 | Per-channel completed-transfer strobe |
| ch_en | output | 4 | Channel enable bits |
| tc_o | output | 4 | Terminal-count flag per channel |
| mark_o | output | 4 | 128-cycle mark flag per channel |
| ch_type | output | 8 | Transfer type, two bits per channel |

## Verification
The checks assume that a register write, a register read and a transfer strobe on the same channel never fall in the same cycle. They also assume that `wr_en` and `rd_en` are never high together. The stop-at-count check leaves out cycles that carry a register write, because a control write in that cycle may legally set the enable again. The bench issues every register access and every transfer pulse as its own one-cycle operation from tasks, so none of these combinations can arise.

// File: rtl/dmacb_pkg.sv
package dmacb_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned CTL_ADDR  = 8;

  typedef enum logic [1:0] {
    XK_VERIFY  = 2'b00,
    XK_WRITE   = 2'b01,
    XK_READ    = 2'b10,
    XK_ILLEGAL = 2'b11
  } xfer_kind_e;

  typedef struct packed {
    logic reload;
    logic tc_stop;
  } ctl_opt_t;
endpackage

// File: rtl/dmacb_regport.sv
module dmacb_regport
  import dmacb_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [RAW-1:0] reg_addr,
  input  logic [NCH-1:0] en_bits,
  input  logic [1:0]     opt_bits,
  input  logic [NCH-1:0] stop_hit,
  output logic           hi_byte,
  output logic [NCH-1:0] en_q,
  output ctl_opt_t       opt_q
);
  logic           ctl_wr;
  logic           chan_acc;
  logic           hi_d;
  logic [NCH-1:0] en_d;
  ctl_opt_t       opt_d;

  assign ctl_wr   = wr_en && (reg_addr == RAW'(CTL_ADDR));
  assign chan_acc = (wr_en || rd_en) && (reg_addr < RAW'(2*NCH));

  always_comb begin
    hi_d  = hi_byte;
    en_d  = en_q & ~stop_hit;
    opt_d = opt_q;
    if (ctl_wr) begin
      hi_d          = 1'b0;
      en_d          = en_bits;
      opt_d.reload  = opt_bits[1];
      opt_d.tc_stop = opt_bits[0];
    end else if (chan_acc) begin
      hi_d = ~hi_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_byte <= 1'b0;
      en_q    <= '0;
      opt_q   <= '0;
    end else begin
      hi_byte <= hi_d;
      en_q    <= en_d;
      opt_q   <= opt_d;
    end
  end
endmodule

// File: rtl/dmacb_channel.sv
module dmacb_channel
  import dmacb_pkg::*;
#(
  parameter int unsigned CYC_W  = 14,
  parameter int unsigned MARK_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       wr_byte,
  input  logic             wr_addr_lo,
  input  logic             wr_addr_hi,
  input  logic             wr_cnt_lo,
  input  logic             wr_cnt_hi,
  input  logic             step,
  input  logic             reload,
  input  logic [REG_W-1:0] ld_addr,
  input  logic [REG_W-1:0] ld_cnt,
  output logic [REG_W-1:0] addr_q,
  output logic [REG_W-1:0] cnt_q,
  output logic             at_end,
  output logic             at_mark
);
  logic [REG_W-1:0] addr_d;
  logic [REG_W-1:0] cnt_d;

  assign at_end  = (cnt_q[CYC_W-1:0] == '0);
  assign at_mark = (cnt_q[MARK_W-1:0] == '0);

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (wr_addr_lo) begin
      addr_d[7:0] = wr_byte;
    end else if (wr_addr_hi) begin
      addr_d[15:8] = wr_byte;
    end else if (wr_cnt_lo) begin
      cnt_d[7:0] = wr_byte;
    end else if (wr_cnt_hi) begin
      cnt_d[15:8] = wr_byte;
    end else if (reload) begin
      addr_d = ld_addr;
      cnt_d  = ld_cnt;
    end else if (step) begin
      addr_d             = addr_q + 1'b1;
      cnt_d[CYC_W-1:0]   = cnt_q[CYC_W-1:0] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/dmacb_status.sv
module dmacb_status #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_bits,
  input  logic           rd_clr,
  output logic [NCH-1:0] stat_q
);
  logic [NCH-1:0] stat_d;

  always_comb begin
    stat_d = (rd_clr ? '0 : stat_q) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/dmacb_bank.sv
module dmacb_bank
  import dmacb_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned RAW    = 4,
  parameter int unsigned CYC_W  = 14,
  parameter int unsigned MARK_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [NCH-1:0]   xfer_done,
  output logic [NCH-1:0]   ch_en,
  output logic [NCH-1:0]   tc_o,
  output logic [NCH-1:0]   mark_o,
  output logic [2*NCH-1:0] ch_type
);
  localparam int unsigned RL_DST = 2;
  localparam int unsigned RL_SRC = NCH - 1;

  logic             hi_byte;
  ctl_opt_t         ctl_opt;
  logic [NCH-1:0]   stat_q;
  logic [NCH-1:0]   final_hit;
  logic [NCH-1:0]   stop_hit;
  logic [NCH-1:0]   reload;
  logic [NCH-1:0]   at_end;
  logic [NCH-1:0]   at_mark;
  logic             stat_rd;
  logic [REG_W-1:0] addr_q [NCH];
  logic [REG_W-1:0] cnt_q  [NCH];

  assign stat_rd = rd_en && (reg_addr == RAW'(CTL_ADDR));

  dmacb_regport #(.NCH(NCH), .RAW(RAW)) u_regport (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .reg_addr (reg_addr),
    .en_bits  (wr_data[NCH-1:0]),
    .opt_bits (wr_data[7:6]),
    .stop_hit (stop_hit),
    .hi_byte  (hi_byte),
    .en_q     (ch_en),
    .opt_q    (ctl_opt)
  );

  dmacb_status #(.NCH(NCH)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (final_hit),
    .rd_clr   (stat_rd),
    .stat_q   (stat_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_a;
    logic sel_c;
    assign sel_a = wr_en && (reg_addr == RAW'(2*i));
    assign sel_c = wr_en && (reg_addr == RAW'(2*i+1));

    assign final_hit[i] = xfer_done[i] && ch_en[i] && at_end[i];
    if (i == RL_DST) begin : g_rl
      assign reload[i] = final_hit[i] && ctl_opt.reload;
    end else begin : g_norl
      assign reload[i] = 1'b0;
    end
    assign stop_hit[i] = final_hit[i] && ctl_opt.tc_stop && !reload[i];

    dmacb_channel #(.CYC_W(CYC_W), .MARK_W(MARK_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_byte    (wr_data),
      .wr_addr_lo (sel_a && !hi_byte),
      .wr_addr_hi (sel_a && hi_byte),
      .wr_cnt_lo  (sel_c && !hi_byte),
      .wr_cnt_hi  (sel_c && hi_byte),
      .step       (xfer_done[i] && ch_en[i]),
      .reload     (reload[i]),
      .ld_addr    (addr_q[RL_SRC]),
      .ld_cnt     (cnt_q[RL_SRC]),
      .addr_q     (addr_q[i]),
      .cnt_q      (cnt_q[i]),
      .at_end     (at_end[i]),
      .at_mark    (at_mark[i])
    );

    assign tc_o[i]          = ch_en[i] && at_end[i];
    assign mark_o[i]        = ch_en[i] && at_mark[i];
    assign ch_type[2*i +: 2] = cnt_q[i][REG_W-1 -: 2];
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr == RAW'(CTL_ADDR)) begin
      rd_data[NCH-1:0] = stat_q;
    end
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == RAW'(2*i)) begin
        rd_data = hi_byte ? addr_q[i][15:8] : addr_q[i][7:0];
      end else if (reg_addr == RAW'(2*i+1)) begin
        rd_data = hi_byte ? cnt_q[i][15:8] : cnt_q[i][7:0];
      end
    end
  end
endmodule

// File: rtl/dmacb_chk.sv
module dmacb_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned RAW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [RAW-1:0]   reg_addr,
  input logic [NCH-1:0]   xfer_done,
  input logic [NCH-1:0]   ch_en,
  input logic [NCH-1:0]   tc_o,
  input logic [2*NCH-1:0] ch_type,
  input logic             hi_byte,
  input logic [NCH-1:0]   stat_q,
  input logic             reload_on,
  input logic             stop_on
);
  p_ff_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == RAW'(8)) |=> !hi_byte);

  p_ff_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && reg_addr < RAW'(2*NCH)) |=> (hi_byte != $past(hi_byte)));

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && reg_addr == RAW'(8)) |=> (($past(stat_q) & ~stat_q) == '0));

  p_type_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !reload_on) |=> $stable(ch_type));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_tc_sets_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done[i] && tc_o[i]) |=> stat_q[i]);

    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_on && !reload_on && !wr_en && xfer_done[i] && tc_o[i]) |=> !ch_en[i]);

    p_idle_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !ch_en[i]) |=> !ch_en[i]);
  end
endmodule

bind dmacb_bank dmacb_chk #(.NCH(NCH), .RAW(RAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .reg_addr  (reg_addr),
  .xfer_done (xfer_done),
  .ch_en     (ch_en),
  .tc_o      (tc_o),
  .ch_type   (ch_type),
  .hi_byte   (hi_byte),
  .stat_q    (stat_q),
  .reload_on (ctl_opt.reload),
  .stop_on   (ctl_opt.tc_stop)
);

// File: tb/dmacb_bank_bench.sv
`timescale 1ns/1ps
module dmacb_bank_bench;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       rd_en;
  logic [3:0] reg_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [3:0] xfer_done;
  logic [3:0] ch_en;
  logic [3:0] tc_o;
  logic [3:0] mark_o;
  logic [7:0] ch_type;

  int total;
  int bad;
  logic [3:0] cap_tc;
  logic [3:0] cap_mark;

  dmacb_bank u_dmacb_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .reg_addr  (reg_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .xfer_done (xfer_done),
    .ch_en     (ch_en),
    .tc_o      (tc_o),
    .mark_o    (mark_o),
    .ch_type   (ch_type)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr8(a, v[7:0]);
    wr8(a, v[15:8]);
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; reg_addr = a;
    #1 d = rd_data;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo;
    logic [7:0] hi;
    rd8(a, lo);
    rd8(a, hi);
    v = {hi, lo};
  endtask

  task automatic xfer(input int ch);
    xfer_done = 4'(1 << ch);
    #1 cap_tc = tc_o; cap_mark = mark_o;
    tick();
    xfer_done = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    int          nlist [4];
    total = 0; bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; reg_addr = '0; wr_data = '0; xfer_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ch_en", 32'(ch_en), 0);
    chk("R1 tc_o", 32'(tc_o), 0);
    chk("R1 mark_o", 32'(mark_o), 0);
    rd8(4'd8, b);
    chk("R1 status", 32'(b), 0);
    for (int a = 0; a < 8; a++) begin
      rd16(4'(a), v);
      chk("R1 reg", 32'(v), 0);
    end

    // R2 / R12 byte-wise write and readback, all registers
    for (int i = 0; i < 4; i++) begin
      wr16(4'(2*i), 16'h1234 + 16'(i * 16'h1111));
      wr16(4'(2*i+1), {2'(i), 14'h0A5 + 14'(i * 3)});
    end
    for (int i = 0; i < 4; i++) begin
      rd16(4'(2*i), v);
      chk("R2 addr", 32'(v), 32'(16'h1234 + 16'(i * 16'h1111)));
      rd16(4'(2*i+1), v);
      chk("R2 count", 32'(v), 32'({2'(i), 14'h0A5 + 14'(i * 3)}));
      chk("R12 type", 32'(ch_type[2*i +: 2]), 32'(i));
    end

    // R3 control write resets the byte pointer
    wr8(4'd0, 8'h11);
    wr8(4'd8, 8'h00);
    wr8(4'd0, 8'h22);
    wr8(4'd8, 8'h00);
    rd16(4'd0, v);
    chk("R3 pointer", 32'(v), 32'h1222);

    // R4 control layout
    wr8(4'd8, 8'hC5);
    chk("R4 enables", 32'(ch_en), 32'h5);
    wr8(4'd8, 8'h00);
    chk("R4 disable", 32'(ch_en), 0);

    // R6 / R7 / R11 / R8 block sweep on channel 0
    nlist = '{1, 2, 129, 300};
    foreach (nlist[j]) begin
      int n;
      n = nlist[j];
      wr16(4'd0, 16'hFFF0);
      wr16(4'd1, {2'b01, 14'(n - 1)});
      wr8(4'd8, 8'h01);
      rd8(4'd8, b);
      for (int k = 1; k <= n; k++) begin
        xfer(0);
        chk("R6 tc", 32'(cap_tc[0]), 32'(k == n));
        chk("R7 mark", 32'(cap_mark[0]), 32'(((n - k) % 128) == 0));
      end
      rd16(4'd0, v);
      chk("R5 addr step", 32'(v), 32'(16'(16'hFFF0 + n)));
      rd16(4'd1, v);
      chk("R11 wrap", 32'(v), 32'h7FFF);
      chk("R11 still on", 32'(ch_en[0]), 1);
      rd8(4'd8, b);
      chk("R8 status set", 32'(b), 32'h1);
      rd8(4'd8, b);
      chk("R8 status clear", 32'(b), 0);
      wr8(4'd8, 8'h00);
    end

    // R5 disabled channel ignores pulses
    wr16(4'd2, 16'h0400);
    wr16(4'd3, 16'h8000);
    for (int k = 0; k < 3; k++) begin
      xfer(1);
      chk("R5 no tc", 32'(cap_tc[1]), 0);
    end
    rd16(4'd2, v);
    chk("R5 addr held", 32'(v), 32'h0400);
    rd16(4'd3, v);
    chk("R5 count held", 32'(v), 32'h8000);
    rd8(4'd8, b);
    chk("R5 no status", 32'(b), 0);

    // R9 stop at terminal count
    wr16(4'd3, 16'h0002);
    wr8(4'd8, 8'h42);
    for (int k = 1; k <= 3; k++) begin
      xfer(1);
      chk("R9 tc", 32'(cap_tc[1]), 32'(k == 3));
    end
    chk("R9 en cleared", 32'(ch_en), 0);
    xfer(1);
    rd16(4'd3, v);
    chk("R9 count frozen", 32'(v), 32'h3FFF);
    rd16(4'd2, v);
    chk("R9 addr frozen", 32'(v), 32'h0403);
    rd8(4'd8, b);
    chk("R9 status", 32'(b), 32'h2);

    // R10 reload of channel 2 from channel 3
    wr8(4'd8, 8'h00);
    wr16(4'd6, 16'h4000);
    wr16(4'd7, 16'h8005);
    wr16(4'd4, 16'h2000);
    wr16(4'd5, 16'h4001);
    wr8(4'd8, 8'hC4);
    xfer(2);
    xfer(2);
    chk("R10 tc seen", 32'(cap_tc[2]), 1);
    chk("R10 still on", 32'(ch_en[2]), 1);
    rd16(4'd4, v);
    chk("R10 addr load", 32'(v), 32'h4000);
    rd16(4'd5, v);
    chk("R10 count load", 32'(v), 32'h8005);
    chk("R12 type reload", 32'(ch_type[5:4]), 32'h2);
    xfer(2);
    rd16(4'd4, v);
    chk("R10 next block", 32'(v), 32'h4001);
    rd16(4'd5, v);
    chk("R10 next count", 32'(v), 32'h8004);
    rd16(4'd6, v);
    chk("R10 src kept", 32'(v), 32'h4000);
    rd16(4'd7, v);
    chk("R10 src count", 32'(v), 32'h8005);
    rd8(4'd8, b);
    chk("R10 status", 32'(b), 32'h4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule